// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit

This is the execute-stage arithmetic-logic unit of a small 32-bit integer core. It has no state. It takes two operands and a 4-bit operation code and returns one result of the same width in the same cycle. It also drives a flag that is high whenever that result is all zeros, so that branch or compare logic outside the block can use it.

The first operand normally comes from the register file. The second comes either from the register file or from an immediate that decode has already sign-extended. The block does not see which of the two it is. It decodes no instructions and holds no registers. The width is a parameter. It must be a power of two, and the shift amount takes its low log2(WIDTH) bits from the second operand.

Top module: `rv_alu`

## Requirements
- R1: With op_sel = 0 (add), result equals (opa + opb) modulo 2^WIDTH; carry out is discarded and no overflow indication exists.
- R2: With op_sel = 1 (subtract), result equals (opa - opb) modulo 2^WIDTH.
- R3: With op_sel = 2 (signed less-than), result is 1 when opa is below opb as two's-complement numbers and 0 otherwise; all bits above bit 0 are zero.
- R4: With op_sel = 3 (unsigned less-than), result is 1 when opa is below opb as unsigned numbers and 0 otherwise; all bits above bit 0 are zero.
- R5: With op_sel = 4, 5 and 6 the result is the bitwise AND, OR and XOR of opa and opb, respectively, across all bits.
- R6: With op_sel = 7 (shift left), result is opa shifted left by opb[log2(WIDTH)-1:0] with zeros entering at bit 0; the upper bits of opb have no effect.
- R7: With op_sel = 8 (logical shift right), result is opa shifted right by opb[log2(WIDTH)-1:0] with zeros entering from the top; the upper bits of opb have no effect.
- R8: With op_sel = 9 (arithmetic shift right), result is opa shifted right by opb[log2(WIDTH)-1:0] with every vacated bit a copy of opa[WIDTH-1].
- R9: Codes 10 through 15 on op_sel produce a result of all zeros.
- R10: is_zero is 1 exactly when every bit of result is 0, for every operation code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (0..9 defined, 10..15 yield zero) |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand or pre-extended immediate; low bits give the shift amount |
| result | output | WIDTH | Operation result |
| is_zero | output | 1 | High when result is all zeros |

## Verification
Both outputs are due in the same cycle the inputs change, because no register lies between any input and any output. The bench drives a new op_sel, opa and opb just after each rising edge and samples result and is_zero at the following falling edge, half a period later. It compares them there with an arithmetic model. The sweep runs every combination of operation code and operands on a 4-bit copy of the block, and a 32-bit copy gets boundary and random operands.

// File: rtl/rv_alu.sv
module rv_alu #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] result,
  output logic             is_zero
);
  localparam int SHW = $clog2(WIDTH);

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_SLT  = 4'd2;
  localparam logic [3:0] OP_SLTU = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_SLL  = 4'd7;
  localparam logic [3:0] OP_SRL  = 4'd8;
  localparam logic [3:0] OP_SRA  = 4'd9;

  logic [SHW-1:0] shamt;
  logic           lt_s, lt_u;

  assign shamt = opb[SHW-1:0];
  assign lt_s  = $signed(opa) < $signed(opb);
  assign lt_u  = opa < opb;

  always_comb begin
    case (op_sel)
      OP_ADD:  result = opa + opb;
      OP_SUB:  result = opa - opb;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(WIDTH-1){1'b0}}, lt_u};
      OP_AND:  result = opa & opb;
      OP_OR:   result = opa | opb;
      OP_XOR:  result = opa ^ opb;
      OP_SLL:  result = opa << shamt;
      OP_SRL:  result = opa >> shamt;
      OP_SRA:  result = WIDTH'($signed(opa) >>> shamt);
      default: result = '0;
    endcase
  end

  assign is_zero = ~|result;
endmodule

// File: rtl/rv_alu_chk.sv
module rv_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [WIDTH-1:0] result,
  input logic             is_zero
);
  localparam int SHW = $clog2(WIDTH);

  always_comb begin
    if (op_sel == 4'd0)
      p_add_inverse_r1: assert (WIDTH'(result - opb) == opa);
    if (op_sel == 4'd1)
      p_sub_inverse_r2: assert (WIDTH'(result + opb) == opa);
    if (op_sel == 4'd2)
      p_slt_bool_r3: assert (result[WIDTH-1:1] == '0);
    if (op_sel == 4'd2 && opa[WIDTH-1] != opb[WIDTH-1])
      p_slt_sign_r3: assert (result[0] == opa[WIDTH-1]);
    if (op_sel == 4'd3)
      p_sltu_bool_r4: assert (result[WIDTH-1:1] == '0);
    if (op_sel == 4'd3 && opa == opb)
      p_sltu_equal_r4: assert (result == '0);
    if (op_sel == 4'd4)
      p_and_subset_r5: assert (((result | opa) == opa) && ((result | opb) == opb));
    if (op_sel == 4'd5)
      p_or_superset_r5: assert (((result & opa) == opa) && ((result & opb) == opb));
    if (op_sel == 4'd6)
      p_xor_undo_r5: assert ((result ^ opb) == opa);
    if (op_sel == 4'd7 && opb[SHW-1:0] != '0)
      p_sll_lsb_r6: assert (result[0] == 1'b0);
    if (op_sel == 4'd8 && opb[SHW-1:0] != '0)
      p_srl_msb_r7: assert (result[WIDTH-1] == 1'b0);
    if (op_sel == 4'd9)
      p_sra_sign_r8: assert (result[WIDTH-1] == opa[WIDTH-1]);
    if (op_sel > 4'd9)
      p_unused_zero_r9: assert (result == '0);
    p_zero_flag_r10: assert (is_zero == ($countones(result) == 0));
  end
endmodule

bind rv_alu rv_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .op_sel (op_sel),
  .opa    (opa),
  .opb    (opb),
  .result (result),
  .is_zero(is_zero)
);

// File: tb/tb_rv_alu.sv
`timescale 1ns/1ps
module tb_rv_alu;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [3:0]  op32 = '0;
  logic [31:0] a32 = '0, b32 = '0;
  logic [31:0] r32;
  logic        z32;

  logic [3:0] op4 = '0;
  logic [3:0] a4 = '0, b4 = '0;
  logic [3:0] r4;
  logic       z4;

  rv_alu #(.WIDTH(32)) dut (
    .op_sel(op32), .opa(a32), .opb(b32), .result(r32), .is_zero(z32)
  );

  rv_alu #(.WIDTH(4)) dut_n4 (
    .op_sel(op4), .opa(a4), .opb(b4), .result(r4), .is_zero(z4)
  );

  function automatic logic [63:0] model(int w, int op, logic [63:0] a, logic [63:0] b);
    logic [63:0] mask, top, r;
    int sh;
    mask = (64'd1 << w) - 64'd1;
    top  = 64'd1 << (w - 1);
    sh   = int'(b & 64'(w - 1));
    case (op)
      0: r = (a + b) & mask;
      1: r = (a + (mask + 64'd1) - b) & mask;
      2: r = ((a ^ top) < (b ^ top)) ? 64'd1 : 64'd0;
      3: r = (a < b) ? 64'd1 : 64'd0;
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = (a << sh) & mask;
      8: r = a >> sh;
      9: begin
        r = a >> sh;
        if ((a & top) != 0) r = r | (mask & ~(mask >> sh));
      end
      default: r = 64'd0;
    endcase
    return r;
  endfunction

  function automatic string req_of(int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5, 6: return "R5";
      7: return "R6";
      8: return "R7";
      9: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run32(int op, logic [31:0] a, logic [31:0] b);
    logic [63:0] e;
    @(posedge clk);
    #0.5;
    op32 = 4'(op); a32 = a; b32 = b;
    @(negedge clk);
    e = model(32, op, {32'd0, a}, {32'd0, b});
    check(req_of(op), {32'd0, r32}, e);
    check("R10", {63'd0, z32}, {63'd0, (e == 0)});
  endtask

  task automatic run4(int op, int a, int b);
    logic [63:0] e;
    @(posedge clk);
    #0.5;
    op4 = 4'(op); a4 = 4'(a); b4 = 4'(b);
    @(negedge clk);
    e = model(4, op, 64'(a), 64'(b));
    check(req_of(op), {60'd0, r4}, e);
    check("R10", {63'd0, z4}, {63'd0, (e == 0)});
  endtask

  logic [31:0] corners [10] = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000,
                                32'hffffffff, 32'h1f, 32'h20, 32'h21,
                                32'hdeadbeef, 32'h12345678};

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R10 idle", {63'd0, z32}, 64'd1);
    check("R1 idle", {32'd0, r32}, 64'd0);

    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run4(op, a, b);

    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run32(op, corners[i], corners[j]);

    // R6 R7 R8: upper bits of opb must not change the shift amount
    run32(7, 32'h00000081, 32'hffffffe3);
    run32(8, 32'h80000000, 32'h0000ff1f);
    run32(9, 32'h80000000, 32'h7fffffe4);

    for (int k = 0; k < 1500; k++)
      run32(k % 16, $urandom, $urandom);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule